// File: doc/BRIEF.md
# Logical Register-Form Execute Unit

This block is the execute stage for the two register-to-register logical operations of a 64-bit load/store architecture: AND and AND-with-complement. Each clock in which the valid strobe is high, it decodes one 32-bit instruction word, reads two 64-bit source operands from its own 32-entry general-purpose register file, and writes the bitwise result back on the same clock edge. When the record flag is set, it also updates a 4-bit condition field, CR0, from a signed compare of the 64-bit result against zero. The fourth bit of CR0 is taken from the summary-overflow input. The block never writes the overflow state itself.

Decode sorts every cycle into one of four operation classes, held in an enum with a `unique case`:
- `OPC_NONE`: no valid instruction.
- `OPC_AND`: the result is RS & RB.
- `OPC_ANDC`: the result is RS & ~RB.
- `OPC_BAD`: the word is not one of the two supported operations.

There are no multi-cycle states. The class depends only on the current inputs. `OPC_AND` and `OPC_ANDC` write the register file, and they write CR0 when the record flag is set. `OPC_BAD` only raises the illegal flag.

A maintenance port can read any register combinationally and write any register. This is the only way to load operands, because the instructions themselves can only combine values already in the file.

Top module: `lxe_exec_unit`

## Requirements
- R1: With `instr_valid` high, primary opcode (word bits [31:26]) equal to 31 and extended opcode (word bits [10:1]) equal to 28, the register named by bits [20:16] receives RS & RB at the next rising edge.
- R2: With extended opcode 60 (primary 31), the destination receives RS & ~RB instead.
- R3: The first source RS is named by word bits [25:21] and the second source RB by bits [15:11]. The destination is bits [20:16]. No source register is modified unless it is also the destination.
- R4: When the record flag (word bit [0]) is 0, `cr0_we` stays low and `cr0_val` does not change, whatever `xer_so` is.
- R5: When the record flag is 1 on a supported operation, `cr0_we` is high in that cycle. At the edge, `cr0_val` becomes {LT, GT, EQ, SO}, MSB first, where exactly one of LT, GT and EQ is set by a signed compare of the 64-bit result against zero.
- R6: The compare uses all 64 bits, so a result whose low 32 bits are zero but whose upper bits are nonzero and positive gives GT.
- R7: The SO bit of the new CR0 is the value of `xer_so` in the cycle of the write.
- R8: A valid word with a primary opcode other than 31, or with primary 31 and an extended opcode other than 28 or 60, raises `illegal` in the same cycle. It writes neither the register file nor CR0.
- R9: With `instr_valid` low, `illegal` and `cr0_we` are low and nothing in the register file or CR0 changes because of the instruction word.
- R10: A synchronous active-high `rst` clears all 32 registers and CR0 to zero.
- R11: `dbg_rdata` shows register `dbg_addr` combinationally. `dbg_we` writes `dbg_wdata` there at the edge. If an instruction writes the same register on the same edge, the instruction result wins.
- R12: AND of a register with itself into itself, with the record flag set, leaves the register value unchanged and updates CR0 only.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| xer_so | input | 1 | Current summary-overflow bit |
| dbg_we | input | 1 | Maintenance write enable |
| dbg_addr | input | 5 | Maintenance register index |
| dbg_wdata | input | XLEN | Maintenance write data |
| dbg_rdata | output | XLEN | Contents of register `dbg_addr` |
| cr0_val | output | 4 | Current CR0 {LT, GT, EQ, SO} |
| cr0_we | output | 1 | CR0 is written at the coming edge |
| illegal | output | 1 | Unsupported valid instruction this cycle |

## Verification
The hardest case to reach is one where a 32-bit compare and a 64-bit compare disagree: a record-form result with a zero low word and a nonzero high word. That operand can only come from the maintenance port, so the stimulus first preloads such a value and a negative value. It then ANDs each register with itself under the record flag, checking both the CR0 code and that the register kept its value. A second hard case is a maintenance write and an instruction write aimed at the same register on the same edge. The stimulus issues both in one cycle and then reads the register back to see which one won.

// File: rtl/lxe_pkg.sv
package lxe_pkg;

    localparam int NREG    = 32;
    localparam int RAW     = 5;
    localparam int PO_W    = 6;
    localparam int XO_W    = 10;
    localparam logic [PO_W-1:0] PO_LOGIC = 6'd31;
    localparam logic [XO_W-1:0] XO_AND   = 10'd28;
    localparam logic [XO_W-1:0] XO_ANDC  = 10'd60;

    typedef enum logic [1:0] {
        OPC_NONE,
        OPC_AND,
        OPC_ANDC,
        OPC_BAD
    } opclass_e;

    typedef struct packed {
        opclass_e       cls;
        logic [RAW-1:0] src_s;
        logic [RAW-1:0] dst_a;
        logic [RAW-1:0] src_b;
        logic           rec;
    } dec_t;

endpackage

// File: rtl/lxe_decode.sv
module lxe_decode
    import lxe_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    output dec_t        dec
);

    logic [PO_W-1:0] po;
    logic [XO_W-1:0] xo;

    always_comb begin
        po        = word[31:26];
        xo        = word[10:1];
        dec.src_s = word[25:21];
        dec.dst_a = word[20:16];
        dec.src_b = word[15:11];
        dec.rec   = word[0];
        if (!valid) begin
            dec.cls = OPC_NONE;
        end else if (po != PO_LOGIC) begin
            dec.cls = OPC_BAD;
        end else begin
            unique case (xo)
                XO_AND:  dec.cls = OPC_AND;
                XO_ANDC: dec.cls = OPC_ANDC;
                default: dec.cls = OPC_BAD;
            endcase
        end
    end

endmodule

// File: rtl/lxe_regfile.sv
module lxe_regfile
    import lxe_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  rd_s_addr,
    input  logic [RAW-1:0]  rd_b_addr,
    output logic [XLEN-1:0] rd_s_data,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            ins_we,
    input  logic [RAW-1:0]  ins_addr,
    input  logic [XLEN-1:0] ins_data,
    input  logic            mnt_we,
    input  logic [RAW-1:0]  mnt_addr,
    input  logic [XLEN-1:0] mnt_wdata,
    output logic [XLEN-1:0] mnt_rdata
);

    logic [XLEN-1:0] mem [NREG];

    // Last assignment wins: the instruction result overrides a maintenance write.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (mnt_we) mem[mnt_addr] <= mnt_wdata;
            if (ins_we) mem[ins_addr] <= ins_data;
        end
    end

    assign rd_s_data = mem[rd_s_addr];
    assign rd_b_data = mem[rd_b_addr];
    assign mnt_rdata = mem[mnt_addr];

    // R10: every register reads zero on the cycle after reset
    a_r10_reset_zero: assert property (@(posedge clk)
        rst |=> (mnt_rdata == '0));

    // R11: a maintenance write lands when no instruction write collides with it
    a_r11_mnt_write: assert property (@(posedge clk) disable iff (rst)
        (mnt_we && !(ins_we && ins_addr == mnt_addr))
        |=> (mem[$past(mnt_addr)] == $past(mnt_wdata)));

    // R11: on a collision the instruction result wins
    a_r11_ins_wins: assert property (@(posedge clk) disable iff (rst)
        (mnt_we && ins_we && ins_addr == mnt_addr)
        |=> (mem[$past(ins_addr)] == $past(ins_data)));

endmodule

// File: rtl/lxe_logic_unit.sv
module lxe_logic_unit
    import lxe_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  opclass_e        cls,
    input  logic [XLEN-1:0] op_s,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] res,
    output logic [3:0]      cr_next,
    input  logic            so_in
);

    logic lt, eq, gt;

    always_comb begin
        unique case (cls)
            OPC_ANDC: res = op_s & ~op_b;
            OPC_AND:  res = op_s & op_b;
            default:  res = op_s & op_b;
        endcase
    end

    // Sign bit and a full-width zero test: no narrowing of the result.
    always_comb begin
        lt      = res[XLEN-1];
        eq      = (res == '0);
        gt      = !lt && !eq;
        cr_next = {lt, gt, eq, so_in};
    end

endmodule

// File: rtl/lxe_exec_unit.sv
module lxe_exec_unit
    import lxe_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr_word,
    input  logic            xer_so,
    input  logic            dbg_we,
    input  logic [4:0]      dbg_addr,
    input  logic [XLEN-1:0] dbg_wdata,
    output logic [XLEN-1:0] dbg_rdata,
    output logic [3:0]      cr0_val,
    output logic            cr0_we,
    output logic            illegal
);

    dec_t            dec;
    logic [XLEN-1:0] s_data, b_data, result;
    logic [3:0]      cr_next;
    logic [3:0]      cr0_q;
    logic            rf_we;

    lxe_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .dec   (dec)
    );

    lxe_regfile #(.XLEN(XLEN)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_s_addr (dec.src_s),
        .rd_b_addr (dec.src_b),
        .rd_s_data (s_data),
        .rd_b_data (b_data),
        .ins_we    (rf_we),
        .ins_addr  (dec.dst_a),
        .ins_data  (result),
        .mnt_we    (dbg_we),
        .mnt_addr  (dbg_addr),
        .mnt_wdata (dbg_wdata),
        .mnt_rdata (dbg_rdata)
    );

    lxe_logic_unit #(.XLEN(XLEN)) u_alu (
        .cls     (dec.cls),
        .op_s    (s_data),
        .op_b    (b_data),
        .res     (result),
        .cr_next (cr_next),
        .so_in   (xer_so)
    );

    always_comb begin
        rf_we   = 1'b0;
        illegal = 1'b0;
        unique case (dec.cls)
            OPC_AND, OPC_ANDC: rf_we   = 1'b1;
            OPC_BAD:           illegal = 1'b1;
            OPC_NONE:          ;
        endcase
        cr0_we = rf_we && dec.rec;
    end

    always_ff @(posedge clk) begin
        if (rst)         cr0_q <= '0;
        else if (cr0_we) cr0_q <= cr_next;
    end

    assign cr0_val = cr0_q;

    // R4: the record flag clear never writes CR0
    a_r4_no_rec_write: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !instr_word[0]) |-> !cr0_we);

    // R4: CR0 holds when not written
    a_r4_cr_hold: assert property (@(posedge clk) disable iff (rst)
        !cr0_we |=> $stable(cr0_val));

    // R5: a written CR0 carries exactly one compare outcome
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        cr0_we |=> ($countones(cr0_val[3:1]) == 1));

    // R7: SO bit follows the overflow input of the write cycle
    a_r7_so_copy: assert property (@(posedge clk) disable iff (rst)
        cr0_we |=> (cr0_val[0] == $past(xer_so)));

    // R8: an unsupported word writes nothing
    a_r8_bad_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!cr0_we && !rf_we));

    // R9: no valid strobe, no effect
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!illegal && !cr0_we && !rf_we));

endmodule

// File: tb/sim_lxe_exec_unit.sv
`timescale 1ns/1ps
module sim_lxe_exec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        xer_so;
    logic        dbg_we;
    logic [4:0]  dbg_addr;
    logic [63:0] dbg_wdata;
    logic [63:0] dbg_rdata;
    logic [3:0]  cr0_val;
    logic        cr0_we;
    logic        illegal;

    always #4 clk = ~clk;

    lxe_exec_unit u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .xer_so(xer_so), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .cr0_val(cr0_val), .cr0_we(cr0_we), .illegal(illegal)
    );

    logic [63:0] m_reg [32];
    logic [3:0]  m_cr;
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int xo, input int rs, input int ra, input int rb, input bit rc);
        return {6'd31, 5'(rs), 5'(ra), 5'(rb), 10'(xo), rc};
    endfunction

    function automatic logic [63:0] pat(input int i);
        return {32'(i * 32'h9E3779B9), 32'(i * 32'h85EBCA6B) ^ 32'h5BD1E995};
    endfunction

    // One clock of stimulus; the model advances at the edge and everything is compared.
    task automatic step(input bit v, input logic [31:0] iw, input bit so,
                        input bit dwe, input int da, input logic [63:0] dwd, input string tag);
        bit legal, ex_ill, ex_we;
        logic [63:0] res;
        logic signed [63:0] sres;
        int rs, ra, rb;
        rs = int'(iw[25:21]); ra = int'(iw[20:16]); rb = int'(iw[15:11]);
        legal  = v && iw[31:26] == 6'd31 && (iw[10:1] == 10'd28 || iw[10:1] == 10'd60);
        ex_ill = v && !legal;
        ex_we  = legal && iw[0];
        res = (iw[10:1] == 10'd60) ? (m_reg[rs] & ~m_reg[rb]) : (m_reg[rs] & m_reg[rb]);
        sres = res;
        instr_valid = v; instr_word = iw; xer_so = so;
        dbg_we = dwe; dbg_addr = 5'(da); dbg_wdata = dwd;
        #1;
        chk(tag, "illegal", 64'(illegal), 64'(ex_ill));
        chk(tag, "cr0_we", 64'(cr0_we), 64'(ex_we));
        chk(tag, "dbg_rdata", dbg_rdata, m_reg[da]);
        @(posedge clk);
        if (dwe) m_reg[da] = dwd;
        if (legal) m_reg[ra] = res;
        if (ex_we) m_cr = {sres < 0, sres > 0, sres == 0, so};
        @(negedge clk);
        chk(tag, "cr0_val", 64'(cr0_val), 64'(m_cr));
    endtask

    task automatic idle_read(input int da, input string tag);
        step(0, 32'h0, 0, 0, da, 64'h0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        instr_valid = 0; instr_word = 0; xer_so = 0; dbg_we = 0; dbg_addr = 0; dbg_wdata = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_cr = '0;
        chk("R10", "cr0_val after reset", 64'(cr0_val), 64'h0);
        for (int i = 0; i < 32; i++) idle_read(i, "R10");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R11: preload through the maintenance port and read back
        for (int i = 0; i < 32; i++) step(0, 32'h0, 0, 1, i, pat(i), "R11");
        step(0, 32'h0, 0, 1, 1, 64'h0000_0001_0000_0000, "R11");
        step(0, 32'h0, 0, 1, 2, 64'hFFFF_FFFF_0000_F0F0, "R11");
        step(0, 32'h0, 0, 1, 3, 64'h0, "R11");
        step(0, 32'h0, 0, 1, 4, 64'h8000_0000_0000_0000, "R11");
        for (int i = 0; i < 32; i++) idle_read(i, "R11");

        // R1: AND without record
        step(1, mk(28, 5, 10, 6, 0), 0, 0, 10, 64'h0, "R1");
        idle_read(10, "R1");
        // R3: field roles, sources untouched
        step(1, mk(28, 7, 8, 9, 0), 0, 0, 7, 64'h0, "R3");
        idle_read(8, "R3"); idle_read(7, "R3"); idle_read(9, "R3");
        // R2: AND-with-complement with record
        step(1, mk(60, 2, 11, 5, 1), 0, 0, 11, 64'h0, "R2");
        idle_read(11, "R2");
        step(1, mk(60, 6, 14, 6, 1), 1, 0, 14, 64'h0, "R2");
        idle_read(14, "R2");
        // R5: negative, zero and positive results
        step(1, mk(28, 4, 15, 4, 1), 0, 0, 15, 64'h0, "R5");
        step(1, mk(28, 3, 16, 5, 1), 0, 0, 16, 64'h0, "R5");
        step(1, mk(28, 5, 17, 5, 1), 0, 0, 17, 64'h0, "R5");
        // R6: only the upper half is set
        step(1, mk(28, 1, 1, 1, 1), 0, 0, 1, 64'h0, "R6");
        idle_read(1, "R6");
        // R7: SO copied from the input
        step(1, mk(28, 3, 18, 3, 1), 1, 0, 18, 64'h0, "R7");
        step(1, mk(28, 4, 19, 4, 1), 1, 0, 19, 64'h0, "R7");
        // R4: record clear keeps CR0 even with SO high
        step(1, mk(28, 5, 20, 6, 0), 1, 0, 20, 64'h0, "R4");
        step(1, mk(60, 5, 21, 6, 0), 0, 0, 21, 64'h0, "R4");
        // R12: self AND
        step(1, mk(28, 12, 12, 12, 1), 0, 0, 12, 64'h0, "R12");
        idle_read(12, "R12");
        // R8: bad extended and primary opcodes
        step(1, mk(29, 5, 22, 6, 1), 1, 0, 22, 64'h0, "R8");
        idle_read(22, "R8");
        step(1, {6'd30, 5'd5, 5'd23, 5'd6, 10'd28, 1'b1}, 1, 0, 23, 64'h0, "R8");
        idle_read(23, "R8");
        step(1, mk(0, 5, 24, 6, 1), 0, 0, 24, 64'h0, "R8");
        idle_read(24, "R8");
        // R9: valid low with a legal word
        step(0, mk(28, 3, 25, 3, 1), 1, 0, 25, 64'h0, "R9");
        idle_read(25, "R9");
        // R11: collision, instruction wins
        step(1, mk(28, 5, 13, 6, 0), 0, 1, 13, 64'hDEAD_BEEF_0000_0001, "R11");
        idle_read(13, "R11");
        step(1, mk(28, 5, 26, 6, 0), 0, 1, 27, 64'h1234_5678_9ABC_DEF0, "R11");
        idle_read(27, "R11"); idle_read(26, "R11");

        // R1: mixed traffic
        for (int k = 0; k < 300; k++) begin
            int sel;
            int xo;
            sel = int'($urandom_range(0, 9));
            xo = (sel < 4) ? 28 : (sel < 8) ? 60 : int'($urandom_range(0, 1023));
            step(($urandom_range(0, 7) != 0), mk(xo, int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), 1'($urandom)),
                 1'($urandom), ($urandom_range(0, 3) == 0), int'($urandom_range(0, 31)),
                 {$urandom, $urandom}, "R1");
        end

        // R10: reset in the middle of a run
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule